// File: doc/BRIEF.md
# Multiprecision 16-bit ALU

This block is a two's-complement arithmetic logic unit with a 16-bit datapath and a 5-bit opcode. On each rising clock edge it captures an opcode, two operands, an external carry input and three single-bit sources for the top bit of the halve operations. It executes that operation during the cycle that edge starts. The result is registered at the following edge, and the carry output is the combinational carry of the operation currently executing.

Words wider than 16 bits are handled in two ways. Several units can be chained, each feeding its carry output into the next unit's external carry input. Alternatively, one unit can process the word 16 bits per cycle, least significant part first, using an internal one-bit register that holds the previous cycle's carry. Each arithmetic operation therefore has variants that take the carry into the LSB from a forced 1, from the external input, or from that register. The forced-1 form starts a subtraction. The external form continues a chain of units. The registered form continues a multi-cycle operation.

Top module: `mpalu`

## Requirements
- R1: An opcode and operands sampled at clock edge k produce `res_o` after edge k+1. Between those edges `res_o` still holds the previous result, and `co_o` shows the carry of the operation being executed.
- R2: A synchronous active-high `rst` clears the result register, the carry register and the captured opcode. After reset, `res_o` is 0 and `co_o` is 0.
- R3: Opcodes 0x01, 0x02 and 0x03 give NOT A plus a carry-in of 1, of `ci_i`, or of the carry register, respectively. The carry out is bit 16 of the 17-bit sum.
- R4: Opcodes 0x04 to 0x07 give A shifted right by one bit with carry out 0. The new bit 15 is taken from a different source for each opcode: A[15] for 0x04, `ral_lsb_i` for 0x05, `rar_lsb_i` for 0x06 and `shf_lsb_i` for 0x07.
- R5: Opcode 0x08 gives A+B+`ci_i`. Opcode 0x09 gives A+B plus the carry register. The carry out is bit 16 of the sum.
- R6: Opcodes 0x0A, 0x0B and 0x0C give A + NOT B with a carry-in of 1, `ci_i`, or the carry register, respectively.
- R7: Opcodes 0x0D, 0x0E and 0x0F give NOT A + B with a carry-in of 1, `ci_i`, or the carry register, respectively.
- R8: Opcodes 0x10 to 0x17 give, in this order: A AND B, A AND NOT B, NOT A AND B, A OR B, NOT A OR B, A XOR B, A, and NOT A. The carry out is 0.
- R9: Opcodes 0x18 to 0x1B give 0. Opcodes 0x1C, 0x1D, 0x1E and 0x1F give 0x0001, 0x00FF, 0x000F and 0x5555. For all of 0x10 to 0x1F the carry out is 0.
- R10: At every clock edge outside reset, the carry register loads the current `co_o`. Any non-arithmetic opcode therefore leaves it at 0.
- R11: Opcode 0x00 gives a result of 0 and a carry of 0, which clears both the result register and the carry register.
- R12: A 64-bit sum can be built in four consecutive cycles. The first cycle uses 0x08 with `ci_i`=0 and the next three use 0x09. A 32-bit difference can be built in two cycles with 0x0A followed by 0x0C.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register loads on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Opcode |
| a_i | input | 16 | Operand A |
| b_i | input | 16 | Operand B |
| ci_i | input | 1 | External carry into the LSB |
| ral_lsb_i | input | 1 | Bit 15 source for opcode 0x05 |
| rar_lsb_i | input | 1 | Bit 15 source for opcode 0x06 |
| shf_lsb_i | input | 1 | Bit 15 source for opcode 0x07 |
| res_o | output | 16 | Registered result |
| co_o | output | 1 | Carry out of the executing operation |

## Verification
The hardest behaviour to observe is the carry register, because it is internal. It only becomes visible when a registered-carry opcode runs in the very next cycle. The stimulus therefore issues one operation per clock with no idle cycles, so that each operation sees exactly the carry left by the one before it. The 64-bit and 32-bit chains, the clear-then-add and reset-then-add sequences, and a long random sweep of all 32 opcodes each exercise this. In every case the bench predicts the carry from its own model of the previous operation.

// File: rtl/mpalu_pkg.sv
package mpalu_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 5;

    typedef enum logic [OP_W-1:0] {
        OP_CLEAR     = 5'h00,
        OP_NEG_ONE   = 5'h01,
        OP_NEG_EXT   = 5'h02,
        OP_NEG_REG   = 5'h03,
        OP_HALF_SGN  = 5'h04,
        OP_HALF_LFT  = 5'h05,
        OP_HALF_RGT  = 5'h06,
        OP_HALF_SHF  = 5'h07,
        OP_ADD_EXT   = 5'h08,
        OP_ADD_REG   = 5'h09,
        OP_AMB_ONE   = 5'h0A,
        OP_AMB_EXT   = 5'h0B,
        OP_AMB_REG   = 5'h0C,
        OP_BMA_ONE   = 5'h0D,
        OP_BMA_EXT   = 5'h0E,
        OP_BMA_REG   = 5'h0F,
        OP_AND       = 5'h10,
        OP_AND_NB    = 5'h11,
        OP_NA_AND    = 5'h12,
        OP_OR        = 5'h13,
        OP_NA_OR     = 5'h14,
        OP_XOR       = 5'h15,
        OP_PASS      = 5'h16,
        OP_INVERT    = 5'h17,
        OP_ZERO_0    = 5'h18,
        OP_ZERO_1    = 5'h19,
        OP_ZERO_2    = 5'h1A,
        OP_ZERO_3    = 5'h1B,
        OP_K_ONE     = 5'h1C,
        OP_K_BYTE    = 5'h1D,
        OP_K_NIB     = 5'h1E,
        OP_K_ALT     = 5'h1F
    } opcode_e;

    typedef enum logic [1:0] {PATH_ARITH, PATH_HALF, PATH_LOGIC, PATH_CONST} path_e;
    typedef enum logic [1:0] {CIN_ONE, CIN_EXT, CIN_REG, CIN_ZERO}           cin_e;
    typedef enum logic [1:0] {MSB_SIGN, MSB_LEFT, MSB_RIGHT, MSB_SHIFT}      msb_e;
    typedef enum logic [2:0] {LG_AND, LG_ANDNB, LG_NAANDB, LG_OR,
                              LG_NAORB, LG_XOR, LG_PASS, LG_INV}              lfn_e;
    typedef enum logic [2:0] {KV_ZERO, KV_ONE, KV_BYTE, KV_NIB, KV_ALT}      kval_e;

    typedef struct packed {
        path_e path;
        logic  inv_a;
        logic  inv_b;
        logic  use_b;
        cin_e  cin;
        msb_e  msb;
        lfn_e  lfn;
        kval_e kval;
    } ctrl_t;

    typedef struct packed {
        logic left;
        logic right;
        logic shift;
    } msbsrc_t;

    // carry-in selection for the three variants of one arithmetic group
    function automatic cin_e variant_cin(input logic [1:0] sel);
        case (sel)
            2'd0:    return CIN_ONE;
            2'd1:    return CIN_EXT;
            default: return CIN_REG;
        endcase
    endfunction

endpackage

// File: rtl/mpalu_decode.sv
module mpalu_decode
    import mpalu_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output ctrl_t           ctrl
);

    opcode_e opc;
    assign opc = opcode_e'(op);

    always_comb begin
        ctrl       = '0;
        ctrl.path  = PATH_CONST;
        ctrl.cin   = CIN_ZERO;
        ctrl.msb   = MSB_SIGN;
        ctrl.lfn   = LG_AND;
        ctrl.kval  = KV_ZERO;
        unique case (opc)
            OP_CLEAR: ctrl.kval = KV_ZERO;
            OP_NEG_ONE, OP_NEG_EXT, OP_NEG_REG: begin
                ctrl.path  = PATH_ARITH;
                ctrl.inv_a = 1'b1;
                ctrl.cin   = variant_cin(op[1:0] - 2'd1);
            end
            OP_HALF_SGN, OP_HALF_LFT, OP_HALF_RGT, OP_HALF_SHF: begin
                ctrl.path = PATH_HALF;
                ctrl.msb  = msb_e'(op[1:0]);
            end
            OP_ADD_EXT, OP_ADD_REG: begin
                ctrl.path  = PATH_ARITH;
                ctrl.use_b = 1'b1;
                ctrl.cin   = op[0] ? CIN_REG : CIN_EXT;
            end
            OP_AMB_ONE, OP_AMB_EXT, OP_AMB_REG: begin
                ctrl.path  = PATH_ARITH;
                ctrl.use_b = 1'b1;
                ctrl.inv_b = 1'b1;
                ctrl.cin   = variant_cin(op[1:0] - 2'd2);
            end
            OP_BMA_ONE, OP_BMA_EXT, OP_BMA_REG: begin
                ctrl.path  = PATH_ARITH;
                ctrl.use_b = 1'b1;
                ctrl.inv_a = 1'b1;
                ctrl.cin   = variant_cin(op[1:0] - 2'd1);
            end
            OP_AND, OP_AND_NB, OP_NA_AND, OP_OR,
            OP_NA_OR, OP_XOR, OP_PASS, OP_INVERT: begin
                ctrl.path = PATH_LOGIC;
                ctrl.lfn  = lfn_e'(op[2:0]);
            end
            OP_ZERO_0, OP_ZERO_1, OP_ZERO_2, OP_ZERO_3: ctrl.kval = KV_ZERO;
            OP_K_ONE:  ctrl.kval = KV_ONE;
            OP_K_BYTE: ctrl.kval = KV_BYTE;
            OP_K_NIB:  ctrl.kval = KV_NIB;
            OP_K_ALT:  ctrl.kval = KV_ALT;
            default:   ctrl.kval = KV_ZERO;
        endcase
    end

endmodule

// File: rtl/mpalu_datapath.sv
module mpalu_datapath
    import mpalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  ctrl_t          ctrl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic           ci_ext,
    input  logic           ci_reg,
    input  msbsrc_t        msrc,
    output logic [W-1:0]   res,
    output logic           co
);

    localparam int HALF_W = W / 2;
    localparam int QUAR_W = W / 4;
    localparam logic [W-1:0] K_BYTE_V = {{(W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
    localparam logic [W-1:0] K_NIB_V  = {{(W-QUAR_W){1'b0}}, {QUAR_W{1'b1}}};
    localparam logic [W-1:0] K_ALT_V  = {HALF_W{2'b01}};

    logic [W-1:0] opx, opy, half_v, logic_v, const_v;
    logic [W:0]   sum;
    logic         cin_bit, top_bit;

    // adder path: operand inversion plus selected LSB carry
    always_comb begin
        opx = ctrl.inv_a ? ~a : a;
        opy = ctrl.use_b ? (ctrl.inv_b ? ~b : b) : '0;
        unique case (ctrl.cin)
            CIN_ONE:  cin_bit = 1'b1;
            CIN_EXT:  cin_bit = ci_ext;
            CIN_REG:  cin_bit = ci_reg;
            default:  cin_bit = 1'b0;
        endcase
        sum = {1'b0, opx} + {1'b0, opy} + {{W{1'b0}}, cin_bit};
    end

    // halve path: new top bit from one of four sources
    always_comb begin
        unique case (ctrl.msb)
            MSB_SIGN:  top_bit = a[W-1];
            MSB_LEFT:  top_bit = msrc.left;
            MSB_RIGHT: top_bit = msrc.right;
            default:   top_bit = msrc.shift;
        endcase
        half_v = {top_bit, a[W-1:1]};
    end

    always_comb begin
        unique case (ctrl.lfn)
            LG_AND:    logic_v = a & b;
            LG_ANDNB:  logic_v = a & ~b;
            LG_NAANDB: logic_v = ~a & b;
            LG_OR:     logic_v = a | b;
            LG_NAORB:  logic_v = ~a | b;
            LG_XOR:    logic_v = a ^ b;
            LG_PASS:   logic_v = a;
            default:   logic_v = ~a;
        endcase
    end

    always_comb begin
        unique case (ctrl.kval)
            KV_ONE:  const_v = {{(W-1){1'b0}}, 1'b1};
            KV_BYTE: const_v = K_BYTE_V;
            KV_NIB:  const_v = K_NIB_V;
            KV_ALT:  const_v = K_ALT_V;
            default: const_v = '0;
        endcase
    end

    always_comb begin
        unique case (ctrl.path)
            PATH_ARITH: res = sum[W-1:0];
            PATH_HALF:  res = half_v;
            PATH_LOGIC: res = logic_v;
            default:    res = const_v;
        endcase
        co = (ctrl.path == PATH_ARITH) ? sum[W] : 1'b0;
    end

endmodule

// File: rtl/mpalu.sv
module mpalu
    import mpalu_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic            ci_i,
    input  logic            ral_lsb_i,
    input  logic            rar_lsb_i,
    input  logic            shf_lsb_i,
    output logic [W-1:0]    res_o,
    output logic            co_o
);

    logic [OP_W-1:0] op_q;
    logic [W-1:0]    a_q, b_q, res_q, alu_res;
    logic            ci_q, carry_q, alu_co;
    msbsrc_t         msrc_q;
    ctrl_t           ctrl;

    // capture stage: instruction executes in the cycle after this edge
    always_ff @(posedge clk) begin
        if (rst) begin
            op_q   <= OP_CLEAR;
            a_q    <= '0;
            b_q    <= '0;
            ci_q   <= 1'b0;
            msrc_q <= '0;
        end else begin
            op_q   <= op_i;
            a_q    <= a_i;
            b_q    <= b_i;
            ci_q   <= ci_i;
            msrc_q <= '{left: ral_lsb_i, right: rar_lsb_i, shift: shf_lsb_i};
        end
    end

    mpalu_decode u_decode (
        .op   (op_q),
        .ctrl (ctrl)
    );

    mpalu_datapath #(.W(W)) u_datapath (
        .ctrl   (ctrl),
        .a      (a_q),
        .b      (b_q),
        .ci_ext (ci_q),
        .ci_reg (carry_q),
        .msrc   (msrc_q),
        .res    (alu_res),
        .co     (alu_co)
    );

    // result and carry registers close the execute cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            carry_q <= 1'b0;
        end else begin
            res_q   <= alu_res;
            carry_q <= alu_co;
        end
    end

    assign res_o = res_q;
    assign co_o  = alu_co;

    assert_carry_reg_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> carry_q == $past(co_o));

    assert_upper_carry_zero_R9: assert property (@(posedge clk) disable iff (rst)
        op_q[OP_W-1] |-> co_o == 1'b0);

    assert_clear_all_R11: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_CLEAR) |=> (res_o == '0) && (carry_q == 1'b0));

    assert_halve_sign_R4: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_HALF_SGN) |=> (res_o[W-2:0] == $past(a_q[W-1:1]))
                                  && (res_o[W-1] == $past(a_q[W-1])));

    assert_negate_R3: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_NEG_ONE) |=> res_o == W'(~$past(a_q) + 1'b1));

    assert_pass_R8: assert property (@(posedge clk) disable iff (rst)
        (op_q == OP_PASS) |=> res_o == $past(a_q));

endmodule

// File: tb/mpalu_bench.sv
module mpalu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 32;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  op_i = '0;
    logic [15:0] a_i = '0, b_i = '0;
    logic        ci_i = 1'b0, ral_lsb_i = 1'b0, rar_lsb_i = 1'b0, shf_lsb_i = 1'b0;
    logic [15:0] res_o;
    logic        co_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mpalu u_mpalu (
        .clk(clk), .rst(rst), .op_i(op_i), .a_i(a_i), .b_i(b_i), .ci_i(ci_i),
        .ral_lsb_i(ral_lsb_i), .rar_lsb_i(rar_lsb_i), .shf_lsb_i(shf_lsb_i),
        .res_o(res_o), .co_o(co_o)
    );

    // {op, a, b, ci, l, r, s, expected result, expected carry}
    localparam logic [57:0] VEC [NV] = '{
        {5'h01, 16'h0001, 16'h0000, 4'b0000, 16'hFFFF, 1'b0},
        {5'h01, 16'h0000, 16'h0000, 4'b0000, 16'h0000, 1'b1},
        {5'h02, 16'h0005, 16'h0000, 4'b0000, 16'hFFFA, 1'b0},
        {5'h02, 16'h0000, 16'h0000, 4'b1000, 16'h0000, 1'b1},
        {5'h04, 16'h8004, 16'h0000, 4'b0000, 16'hC002, 1'b0},
        {5'h04, 16'h0006, 16'h0000, 4'b0111, 16'h0003, 1'b0},
        {5'h05, 16'h0004, 16'h0000, 4'b0100, 16'h8002, 1'b0},
        {5'h06, 16'h0003, 16'h0000, 4'b0100, 16'h0001, 1'b0},
        {5'h07, 16'h0002, 16'h0000, 4'b0001, 16'h8001, 1'b0},
        {5'h08, 16'hFFFF, 16'h0001, 4'b0000, 16'h0000, 1'b1},
        {5'h08, 16'h1234, 16'h1111, 4'b1000, 16'h2346, 1'b0},
        {5'h0A, 16'h0005, 16'h0003, 4'b0000, 16'h0002, 1'b1},
        {5'h0B, 16'h0003, 16'h0005, 4'b1000, 16'hFFFE, 1'b0},
        {5'h0D, 16'h0003, 16'h0005, 4'b0000, 16'h0002, 1'b1},
        {5'h0E, 16'h0000, 16'h0000, 4'b0000, 16'hFFFF, 1'b0},
        {5'h10, 16'hF0F0, 16'hFF00, 4'b0000, 16'hF000, 1'b0},
        {5'h11, 16'hF0F0, 16'hFF00, 4'b0000, 16'h00F0, 1'b0},
        {5'h12, 16'hF0F0, 16'hFF00, 4'b0000, 16'h0F00, 1'b0},
        {5'h13, 16'hF0F0, 16'hFF00, 4'b0000, 16'hFFF0, 1'b0},
        {5'h14, 16'hF0F0, 16'hFF00, 4'b0000, 16'hFF0F, 1'b0},
        {5'h15, 16'hF0F0, 16'hFF00, 4'b0000, 16'h0FF0, 1'b0},
        {5'h16, 16'hF0F0, 16'hFF00, 4'b0000, 16'hF0F0, 1'b0},
        {5'h17, 16'hF0F0, 16'hFF00, 4'b0000, 16'h0F0F, 1'b0},
        {5'h18, 16'hFFFF, 16'hFFFF, 4'b1111, 16'h0000, 1'b0},
        {5'h19, 16'hFFFF, 16'h0001, 4'b0000, 16'h0000, 1'b0},
        {5'h1A, 16'h8000, 16'h8000, 4'b0000, 16'h0000, 1'b0},
        {5'h1B, 16'h1234, 16'h4321, 4'b1000, 16'h0000, 1'b0},
        {5'h1C, 16'hFFFF, 16'hFFFF, 4'b1111, 16'h0001, 1'b0},
        {5'h1D, 16'h0000, 16'h0000, 4'b0000, 16'h00FF, 1'b0},
        {5'h1E, 16'h0000, 16'h0000, 4'b0000, 16'h000F, 1'b0},
        {5'h1F, 16'h0000, 16'h0000, 4'b0000, 16'h5555, 1'b0},
        {5'h00, 16'hFFFF, 16'hFFFF, 4'b1111, 16'h0000, 1'b0}
    };

    // independent reference: returns {carry, result}
    function automatic logic [16:0] ref_alu(input logic [4:0] op, input logic [15:0] a, b,
                                            input logic ci, l, r, s, cr);
        logic [16:0] xa, xb, na, nb;
        xa = {1'b0, a};  xb = {1'b0, b};
        na = {1'b0, ~a}; nb = {1'b0, ~b};
        case (op)
            5'h01: return na + 17'd1;
            5'h02: return na + 17'(ci);
            5'h03: return na + 17'(cr);
            5'h04: return {1'b0, a[15], a[15:1]};
            5'h05: return {1'b0, l, a[15:1]};
            5'h06: return {1'b0, r, a[15:1]};
            5'h07: return {1'b0, s, a[15:1]};
            5'h08: return xa + xb + 17'(ci);
            5'h09: return xa + xb + 17'(cr);
            5'h0A: return xa + nb + 17'd1;
            5'h0B: return xa + nb + 17'(ci);
            5'h0C: return xa + nb + 17'(cr);
            5'h0D: return na + xb + 17'd1;
            5'h0E: return na + xb + 17'(ci);
            5'h0F: return na + xb + 17'(cr);
            5'h10: return {1'b0, a & b};
            5'h11: return {1'b0, a & ~b};
            5'h12: return {1'b0, ~a & b};
            5'h13: return {1'b0, a | b};
            5'h14: return {1'b0, ~a | b};
            5'h15: return {1'b0, a ^ b};
            5'h16: return {1'b0, a};
            5'h17: return {1'b0, ~a};
            5'h1C: return 17'h00001;
            5'h1D: return 17'h000FF;
            5'h1E: return 17'h0000F;
            5'h1F: return 17'h05555;
            default: return 17'h0;
        endcase
    endfunction

    function automatic string req_tag(input logic [4:0] op);
        if (op == 5'h00) return "R11";
        if (op <= 5'h03) return "R3";
        if (op <= 5'h07) return "R4";
        if (op <= 5'h09) return "R5";
        if (op <= 5'h0C) return "R6";
        if (op <= 5'h0F) return "R7";
        if (op <= 5'h17) return "R8";
        return "R9";
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // pipeline of pending expectations: stage 1 carry, stage 2 result
    logic        v1 = 1'b0, v2 = 1'b0, e1_co = 1'b0, m_creg = 1'b0;
    logic [15:0] e1_res = '0, e2_res = '0;
    string       t1 = "", t2 = "";

    // called just after a falling edge; returns just after the next one
    task automatic issue(input logic [4:0] op, input logic [15:0] a, b,
                         input logic ci, l, r, s,
                         input logic [15:0] eres, input logic eco, input string tag);
        if (v1) chk(t1, "carry", {15'd0, co_o}, {15'd0, e1_co});
        if (v2) chk(t2, "result", res_o, e2_res);
        v2 = v1; e2_res = e1_res; t2 = t1;
        v1 = 1'b1; e1_res = eres; e1_co = eco; t1 = tag;
        m_creg = eco;
        op_i = op; a_i = a; b_i = b; ci_i = ci;
        ral_lsb_i = l; rar_lsb_i = r; shf_lsb_i = s;
        @(posedge clk); @(negedge clk);
    endtask

    task automatic issue_m(input logic [4:0] op, input logic [15:0] a, b,
                           input logic ci, l, r, s, input string tag);
        logic [16:0] e;
        e = ref_alu(op, a, b, ci, l, r, s, m_creg);
        issue(op, a, b, ci, l, r, s, e[15:0], e[16], tag);
    endtask

    task automatic drain();
        issue(5'h1C, '0, '0, 0, 0, 0, 0, 16'h0001, 1'b0, "R9");
        issue(5'h1C, '0, '0, 0, 0, 0, 0, 16'h0001, 1'b0, "R9");
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(negedge clk);
        rst = 1'b0;
        v1 = 1'b0; v2 = 1'b0; m_creg = 1'b0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [63:0] x64, y64;
        logic [64:0] s64, pc;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R2: state straight out of reset
        chk("R2", "reset result", res_o, 16'h0000);
        chk("R2", "reset carry", {15'd0, co_o}, 16'h0000);

        // R1: result lags capture by one edge
        op_i = 5'h1F;
        @(posedge clk); @(negedge clk);
        chk("R1", "result before register edge", res_o, 16'h0000);
        op_i = 5'h08; a_i = 16'hFFFF; b_i = 16'h0001; ci_i = 1'b0;
        @(posedge clk); @(negedge clk);
        chk("R1", "result after register edge", res_o, 16'h5555);
        chk("R1", "carry during execute", {15'd0, co_o}, 16'h0001);
        // carry register now 1; reset must clear it (R2)
        do_reset();
        chk("R2", "mid-run reset result", res_o, 16'h0000);
        issue(5'h09, 16'h0000, 16'h0000, 0, 0, 0, 0, 16'h0000, 1'b0, "R2");
        drain();

        // vector table walk
        for (int i = 0; i < NV; i++) begin
            logic [57:0] v;
            v = VEC[i];
            issue(v[57:53], v[52:37], v[36:21], v[20], v[19], v[18], v[17],
                  v[16:1], v[0], req_tag(v[57:53]));
        end
        drain();

        // R10: registered carry feeds the next cycle, cleared by logic ops
        issue(5'h08, 16'hFFFF, 16'h0001, 0, 0, 0, 0, 16'h0000, 1'b1, "R10");
        issue(5'h09, 16'h0000, 16'h0000, 0, 0, 0, 0, 16'h0001, 1'b0, "R10");
        issue(5'h0A, 16'h0001, 16'h0001, 0, 0, 0, 0, 16'h0000, 1'b1, "R10");
        issue(5'h16, 16'h1234, 16'h0000, 0, 0, 0, 0, 16'h1234, 1'b0, "R10");
        issue(5'h09, 16'h0000, 16'h0000, 0, 0, 0, 0, 16'h0000, 1'b0, "R10");
        issue(5'h01, 16'h0000, 16'h0000, 0, 0, 0, 0, 16'h0000, 1'b1, "R10");
        issue(5'h03, 16'h0000, 16'h0000, 0, 0, 0, 0, 16'h0000, 1'b1, "R10");
        issue(5'h0F, 16'h0001, 16'h0000, 0, 0, 0, 0, 16'hFFFF, 1'b0, "R10");
        // R11: clear zeroes the carry register
        issue(5'h08, 16'h8000, 16'h8000, 0, 0, 0, 0, 16'h0000, 1'b1, "R11");
        issue(5'h00, 16'h5555, 16'h5555, 1, 1, 1, 1, 16'h0000, 1'b0, "R11");
        issue(5'h09, 16'h0000, 16'h0000, 0, 0, 0, 0, 16'h0000, 1'b0, "R11");
        drain();

        // R12: 64-bit additions over four consecutive cycles
        for (int p = 0; p < 2; p++) begin
            x64 = (p == 0) ? 64'hFFFF_FFFF_FFFF_0001 : 64'h8765_4321_FEDC_BA98;
            y64 = (p == 0) ? 64'h0000_0000_0000_FFFF : 64'h789A_BCDF_0123_4568;
            s64 = {1'b0, x64} + {1'b0, y64};
            for (int k = 0; k < 4; k++) begin
                logic [64:0] mask;
                mask = (65'd1 << (16 * (k + 1))) - 65'd1;
                pc = (({1'b0, x64} & mask) + ({1'b0, y64} & mask)) >> (16 * (k + 1));
                issue((k == 0) ? 5'h08 : 5'h09, x64[16*k +: 16], y64[16*k +: 16],
                      0, 0, 0, 0, s64[16*k +: 16], pc[0], "R12");
            end
        end
        // R12: 32-bit difference 0x00010000 - 0x00000001
        issue(5'h0A, 16'h0000, 16'h0001, 0, 0, 0, 0, 16'hFFFF, 1'b0, "R12");
        issue(5'h0C, 16'h0001, 16'h0000, 0, 0, 0, 0, 16'h0000, 1'b1, "R12");
        drain();

        // randomized sweep of all opcodes, carry chained through the model
        void'($urandom(32'd7));
        for (int i = 0; i < 600; i++) begin
            logic [4:0]  rop;
            logic [15:0] ra, rb;
            logic [3:0]  rf;
            rop = (i < 32) ? 5'(i) : 5'($urandom);
            ra = 16'($urandom); rb = 16'($urandom); rf = 4'($urandom);
            issue_m(rop, ra, rb, rf[3], rf[2], rf[1], rf[0], req_tag(rop));
        end
        drain();

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule